// File: doc/BRIEF.md
# Controller Register Transfer Bridge

This block connects an 8-bit host register window to the 16-bit register-select port and register-value port of a network controller core. The host stages a 16-bit value in a write holding register, one byte at a time. It then sets the target and the direction in a control register and writes any value to a command offset. That write launches exactly one 16-bit transfer.

Each transfer runs through a fixed four-cycle sequence: strobe, wait, capture and done. The host polls a busy flag in the status register until the sequence completes. When the transfer reads from the controller, the returned word is placed in a read holding register. That register is separate from the write holding register.

The same block also drives the controller's active-low reset from a control bit and reflects the controller's active-low interrupt line in the status register. Status and control share one offset: status is returned on reads and control is loaded on writes.

Top module: `ctlr_reg_bridge`

## Requirements
- R1: After reset the bridge is idle (strobe low, status busy bit 0), the controller reset output is low, and both read holding bytes read as 0x00.
- R2: A host write to offset 4 loads the control register. Bit 0 selects the target (1 = register-select port, 0 = register-value port). Bit 1 selects the direction (1 = read from the controller, 0 = write to it). Bit 3 drives `c_rst_n` from the next cycle, so 0 holds the controller in reset and 1 releases it.
- R3: A host read of offset 4 returns status. Bit 5 is busy. Bit 4 follows `c_irq_n` one cycle late, so it is 0 while an interrupt is pending. All other status bits read 0.
- R4: Offsets 0 and 1 hold the low and high bytes of the outgoing word. A host write of any value to offset 5 while idle raises `c_stb` for exactly one cycle, in the cycle after the write, with the staged word and the control target and direction.
- R5: The status busy bit reads 1 in each of the four cycles after a command write that starts a transfer and reads 0 in the fifth.
- R6: A command write while busy is ignored: it produces no second strobe and does not stretch the busy window.
- R7: Target, direction and outgoing word are captured when the transfer starts and held on the controller outputs until it ends. Control or holding-register writes made while busy do not alter the transfer in progress.
- R8: A read transfer loads the controller's `c_rdata`, sampled in the third cycle of the sequence, into the read holding register at offsets 2 (low) and 3 (high). A write transfer leaves the read holding register unchanged.
- R9: The read and write holding registers are distinct. Host reads of offsets 0 and 1 return 0x00, and host writes to offsets 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | 3 | Host register offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (zero when not reading) |
| c_stb | output | 1 | One-cycle transfer strobe to the controller |
| c_sel_rap | output | 1 | Transfer target: 1 register-select port, 0 register-value port |
| c_rd | output | 1 | Transfer direction: 1 read, 0 write |
| c_wdata | output | 16 | Outgoing word |
| c_rdata | input | 16 | Word returned by the controller |
| c_rst_n | output | 1 | Active-low controller reset |
| c_irq_n | input | 1 | Active-low controller interrupt |

## Verification
Each kind of internal fault shows up at the ports within a few cycles:
- A sequencer stuck in, or skipping, a phase shows as a busy bit that is still set on the fifth status poll after a command, or clear on the first four.
- A transfer that uses live control or holding values instead of latched ones lands the wrong word in a controller register, which is visible as soon as the strobe completes.
- A wrong capture, or a capture on a write transfer, corrupts the read holding bytes. The next host read of offsets 2 and 3 exposes it.
- A dropped or repeated launch changes the number of strobes the controller model counts.

// File: rtl/crb_pkg.sv
package crb_pkg;
    // Control register field positions (host write at control offset)
    localparam int CTL_TARGET_BIT = 0;
    localparam int CTL_DIR_BIT    = 1;
    localparam int CTL_RUN_BIT    = 3;
    // Status register field positions (host read at the same offset)
    localparam int STS_IRQN_BIT   = 4;
    localparam int STS_BUSY_BIT   = 5;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_WAIT = 3'd2,
        PH_CAPT = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        logic target_rap;
        logic dir_rd;
        logic run_n;
    } ctl_t;
endpackage

// File: rtl/crb_host_regs.sv
module crb_host_regs
    import crb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOST_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [HOST_W-1:0] h_wdata,
    output logic [HOST_W-1:0] h_rdata,
    input  logic [DATA_W-1:0] rd_hold,
    input  logic              busy,
    input  logic              irq_n,
    output logic [DATA_W-1:0] wr_hold,
    output ctl_t              ctl,
    output logic              go
);
    localparam int NB      = DATA_W / HOST_W;
    localparam int RD_BASE = NB;
    localparam int CTL_OFS = 2 * NB;
    localparam int CMD_OFS = 2 * NB + 1;

    typedef struct packed {
        logic [DATA_W-1:0] wr_hold;
        ctl_t              ctl;
        logic              irq_n;
    } regs_t;

    localparam regs_t REGS_RST = '{wr_hold: '0, ctl: '0, irq_n: 1'b1};

    regs_t regs_d, regs_q;

    logic [NB-1:0] wr_lane;
    logic [NB-1:0] rd_lane;
    logic          ctl_wr_hit;
    logic          ctl_rd_hit;

    // Per-byte decode of the holding-register windows
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign wr_lane[g] = h_wr && (h_addr == ADDR_W'(g));
        assign rd_lane[g] = h_rd && (h_addr == ADDR_W'(RD_BASE + g));
    end

    assign ctl_wr_hit = h_wr && (h_addr == ADDR_W'(CTL_OFS));
    assign ctl_rd_hit = h_rd && (h_addr == ADDR_W'(CTL_OFS));
    assign go         = h_wr && (h_addr == ADDR_W'(CMD_OFS));

    always_comb begin
        regs_d = regs_q;
        for (int b = 0; b < NB; b++) begin
            if (wr_lane[b]) begin
                regs_d.wr_hold[b*HOST_W +: HOST_W] = h_wdata;
            end
        end
        if (ctl_wr_hit) begin
            regs_d.ctl.target_rap = h_wdata[CTL_TARGET_BIT];
            regs_d.ctl.dir_rd     = h_wdata[CTL_DIR_BIT];
            regs_d.ctl.run_n      = h_wdata[CTL_RUN_BIT];
        end
        regs_d.irq_n = irq_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read mux: status at the shared offset, read holding bytes, else zero
    logic [HOST_W-1:0] status;
    always_comb begin
        status               = '0;
        status[STS_BUSY_BIT] = busy;
        status[STS_IRQN_BIT] = regs_q.irq_n;
    end

    always_comb begin
        h_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_lane[b]) begin
                h_rdata = rd_hold[b*HOST_W +: HOST_W];
            end
        end
        if (ctl_rd_hit) begin
            h_rdata = status;
        end
    end

    assign wr_hold = regs_q.wr_hold;
    assign ctl     = regs_q.ctl;
endmodule

// File: rtl/crb_xfer_seq.sv
module crb_xfer_seq
    import crb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              sel_rap,
    input  logic              dir_rd,
    input  logic [DATA_W-1:0] wr_hold,
    input  logic [DATA_W-1:0] c_rdata,
    output logic              c_stb,
    output logic              c_sel_rap,
    output logic              c_rd,
    output logic [DATA_W-1:0] c_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_hold
);
    typedef struct packed {
        phase_e            phase;
        logic              sel;
        logic              rd;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rhold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (go) begin
                    seq_d.phase = PH_ADDR;
                    seq_d.sel   = sel_rap;
                    seq_d.rd    = dir_rd;
                    seq_d.wdata = wr_hold;
                end
            end
            PH_ADDR: seq_d.phase = PH_WAIT;
            PH_WAIT: seq_d.phase = PH_CAPT;
            PH_CAPT: begin
                if (seq_q.rd) begin
                    seq_d.rhold = c_rdata;
                end
                seq_d.phase = PH_DONE;
            end
            PH_DONE: seq_d.phase = PH_IDLE;
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign c_stb     = (seq_q.phase == PH_ADDR);
    assign busy      = (seq_q.phase != PH_IDLE);
    assign c_sel_rap = seq_q.sel;
    assign c_rd      = seq_q.rd;
    assign c_wdata   = seq_q.wdata;
    assign rd_hold   = seq_q.rhold;
endmodule

// File: rtl/ctlr_reg_bridge.sv
module ctlr_reg_bridge
    import crb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HOST_W = 8,
    parameter int ADDR_W = $clog2(2 * (DATA_W / HOST_W) + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [HOST_W-1:0] h_wdata,
    output logic [HOST_W-1:0] h_rdata,
    output logic              c_stb,
    output logic              c_sel_rap,
    output logic              c_rd,
    output logic [DATA_W-1:0] c_wdata,
    input  logic [DATA_W-1:0] c_rdata,
    output logic              c_rst_n,
    input  logic              c_irq_n
);
    logic [DATA_W-1:0] wr_hold;
    logic [DATA_W-1:0] rd_hold;
    ctl_t              ctl;
    logic              go;
    logic              busy;

    crb_host_regs #(
        .DATA_W (DATA_W),
        .HOST_W (HOST_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_addr  (h_addr),
        .h_wr    (h_wr),
        .h_rd    (h_rd),
        .h_wdata (h_wdata),
        .h_rdata (h_rdata),
        .rd_hold (rd_hold),
        .busy    (busy),
        .irq_n   (c_irq_n),
        .wr_hold (wr_hold),
        .ctl     (ctl),
        .go      (go)
    );

    crb_xfer_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .sel_rap   (ctl.target_rap),
        .dir_rd    (ctl.dir_rd),
        .wr_hold   (wr_hold),
        .c_rdata   (c_rdata),
        .c_stb     (c_stb),
        .c_sel_rap (c_sel_rap),
        .c_rd      (c_rd),
        .c_wdata   (c_wdata),
        .busy      (busy),
        .rd_hold   (rd_hold)
    );

    assign c_rst_n = ctl.run_n;
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
    parameter int DATA_W = 16,
    parameter int HOST_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_wr,
    input logic [HOST_W-1:0] h_wdata,
    input logic              c_stb,
    input logic              c_sel_rap,
    input logic              c_rd,
    input logic [DATA_W-1:0] c_wdata,
    input logic              c_rst_n,
    input logic              busy,
    input logic [DATA_W-1:0] rd_hold
);
    localparam int NB      = DATA_W / HOST_W;
    localparam int CTL_OFS = 2 * NB;
    localparam int CMD_OFS = 2 * NB + 1;

    logic cmd_wr;
    logic ctl_wr;
    assign cmd_wr = h_wr && (h_addr == ADDR_W'(CMD_OFS));
    assign ctl_wr = h_wr && (h_addr == ADDR_W'(CTL_OFS));

    assert_reset_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (c_rst_n == $past(h_wdata[3])));

    assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> c_stb);

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_stb |=> !c_stb);

    assert_busy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_stb |-> busy ##1 busy ##1 busy ##1 busy ##1 !busy);

    assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> !c_stb);

    assert_attr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !c_stb) |-> $stable({c_sel_rap, c_rd, c_wdata}));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_hold) |-> $past(busy && c_rd));
endmodule

bind ctlr_reg_bridge crb_checker #(
    .DATA_W (DATA_W),
    .HOST_W (HOST_W),
    .ADDR_W (ADDR_W)
) u_crb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_addr    (h_addr),
    .h_wr      (h_wr),
    .h_wdata   (h_wdata),
    .c_stb     (c_stb),
    .c_sel_rap (c_sel_rap),
    .c_rd      (c_rd),
    .c_wdata   (c_wdata),
    .c_rst_n   (c_rst_n),
    .busy      (busy),
    .rd_hold   (rd_hold)
);

// File: tb/tb_ctlr_reg_bridge.sv
`timescale 1ns/1ps
module tb_ctlr_reg_bridge;
    localparam int DATA_W = 16;
    localparam int HOST_W = 8;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic              h_wr = 1'b0;
    logic              h_rd = 1'b0;
    logic [HOST_W-1:0] h_wdata = '0;
    logic [HOST_W-1:0] h_rdata;
    logic              c_stb, c_sel_rap, c_rd, c_rst_n;
    logic [DATA_W-1:0] c_wdata, c_rdata;
    logic              c_irq_n = 1'b1;

    always #2.5 clk = ~clk;

    ctlr_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .c_stb(c_stb), .c_sel_rap(c_sel_rap),
        .c_rd(c_rd), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_rst_n(c_rst_n),
        .c_irq_n(c_irq_n)
    );

    // Controller model: select register plus four value registers
    logic [15:0] m_rap;
    logic [15:0] m_mem [4];
    int          stb_count;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rap     <= 16'h0;
            m_mem[0]  <= 16'h0;
            m_mem[1]  <= 16'hBEEF;
            m_mem[2]  <= 16'h0;
            m_mem[3]  <= 16'h0;
            stb_count <= 0;
        end else if (c_stb) begin
            stb_count <= stb_count + 1;
            if (!c_rd) begin
                if (c_sel_rap) m_rap <= c_wdata;
                else           m_mem[m_rap[1:0]] <= c_wdata;
            end
        end
    end
    assign c_rdata = c_sel_rap ? m_rap : m_mem[m_rap[1:0]];

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each host read against the queued expectation
    always @(negedge clk) begin
        if (h_rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", h_rdata, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(h_rdata == e.v, e.tag, h_rdata, e.v);
            end
        end
    end

    task automatic op(input logic w, input logic r, input int a, input logic [7:0] d);
        h_wr = w; h_rd = r; h_addr = ADDR_W'(a); h_wdata = d;
        @(posedge clk); #1;
        h_wr = 1'b0; h_rd = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        op(1'b1, 1'b0, a, d);
    endtask

    task automatic nop();
        op(1'b0, 1'b0, 0, 8'h0);
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        exp_t e;
        e.v = exp; e.tag = tag;
        exp_q.push_back(e);
        op(1'b0, 1'b1, a, 8'h0);
    endtask

    task automatic stage(input logic sel, input logic dir, input logic [15:0] data);
        wr(0, data[7:0]);
        wr(1, data[15:8]);
        wr(4, {4'b0, 1'b1, 1'b0, dir, sel});
    endtask

    task automatic xfer(input logic sel, input logic dir, input logic [15:0] data);
        stage(sel, dir, data);
        wr(5, 8'h00);
        repeat (5) nop();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        check(c_rst_n == 1'b0, "R1 c_rst_n after reset", c_rst_n, 0);
        check(c_stb == 1'b0, "R1 strobe idle", c_stb, 0);
        rd(4, 8'h10, "R1 status after reset");
        rd(2, 8'h00, "R1 read hold low");
        rd(3, 8'h00, "R1 read hold high");

        // R2 reset control bit
        wr(4, 8'h08);
        check(c_rst_n == 1'b1, "R2 reset released", c_rst_n, 1);
        wr(4, 8'h00);
        check(c_rst_n == 1'b0, "R2 reset asserted", c_rst_n, 0);

        // R4/R5 write select register = 2, poll busy cycle by cycle
        base = stb_count;
        stage(1'b1, 1'b0, 16'h0002);
        wr(5, 8'h5C);
        rd(4, 8'h30, "R5 busy k1");
        rd(4, 8'h30, "R5 busy k2");
        rd(4, 8'h30, "R5 busy k3");
        rd(4, 8'h30, "R5 busy k4");
        rd(4, 8'h10, "R5 idle k5");
        check(m_rap == 16'h0002, "R4 select reg written", m_rap, 2);
        check(stb_count == base + 1, "R4 one strobe", stb_count - base, 1);

        // R4 write value register 2
        xfer(1'b0, 1'b0, 16'hA55A);
        check(m_mem[2] == 16'hA55A, "R4 value reg written", m_mem[2], 16'hA55A);

        // R2 target select on reads, R8 capture
        xfer(1'b1, 1'b0, 16'h0001);
        xfer(1'b1, 1'b1, 16'h0000);
        rd(2, 8'h01, "R2 read select low");
        rd(3, 8'h00, "R2 read select high");
        xfer(1'b0, 1'b1, 16'h0000);
        rd(2, 8'hEF, "R8 read value low");
        rd(3, 8'hBE, "R8 read value high");

        // R9 holding registers distinct
        rd(0, 8'h00, "R9 write hold low not readable");
        rd(1, 8'h00, "R9 write hold high not readable");
        wr(2, 8'h77);
        wr(3, 8'h66);
        rd(2, 8'hEF, "R9 write to read hold ignored low");
        rd(3, 8'hBE, "R9 write to read hold ignored high");

        // R8 write transfer leaves read hold
        xfer(1'b1, 1'b0, 16'h0003);
        rd(2, 8'hEF, "R8 hold after write low");
        rd(3, 8'hBE, "R8 hold after write high");

        // R7 attributes latched at launch
        stage(1'b0, 1'b0, 16'h1111);
        wr(5, 8'h00);
        wr(4, 8'h0B);
        wr(0, 8'hFF);
        repeat (3) nop();
        check(m_mem[3] == 16'h1111, "R7 value unchanged", m_mem[3], 16'h1111);
        check(m_rap == 16'h0003, "R7 target unchanged", m_rap, 3);
        rd(2, 8'hEF, "R7 direction unchanged");

        // R6 command during busy ignored
        base = stb_count;
        stage(1'b0, 1'b0, 16'h2222);
        wr(5, 8'h00);
        nop();
        wr(5, 8'hFF);
        rd(4, 8'h30, "R6 busy k3");
        rd(4, 8'h30, "R6 busy k4");
        rd(4, 8'h10, "R6 not stretched k5");
        check(stb_count == base + 1, "R6 single strobe", stb_count - base, 1);
        check(m_mem[3] == 16'h2222, "R6 value written once", m_mem[3], 16'h2222);

        // R3 interrupt reflection
        c_irq_n = 1'b0;
        nop();
        rd(4, 8'h00, "R3 irq pending");
        c_irq_n = 1'b1;
        nop();
        rd(4, 8'h10, "R3 irq cleared");

        nop();
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule